// File: doc/BRIEF.md
# Watchdog and Reset Pulse Supervisor

This block is a synchronous supervisor for a microprocessor. It watches a clean supply-valid flag and holds the processor in reset while the supply is invalid. After the supply becomes valid, it keeps reset asserted for a fixed stretch. It also checks that the processor keeps toggling a watchdog strobe. When the strobe stalls, the block issues a reset pulse and drops a sticky watchdog status output. The same supply flag gates a memory chip-enable so that no write can reach memory while the supply is bad.

Timing comes from one of two sources, picked by a two-bit mode input. In external mode every cycle with `ext_tick` high counts as one tick. In the two internal modes a prescaler produces one tick every `PRESCALE` clocks, and every period is a multiple of `INT_UNIT` ticks. After every reset the first watchdog window is the long one. The normal window applies only once the processor has shown life with its first strobe edge.

Top module: `wd_supervisor`

## Requirements
- R1: While `pwr_ok` is low, `rst_n_o` is low from the next clock onward. `rst_o` is always the exact complement of `rst_n_o`.
- R2: Once `pwr_ok` is high, reset stays asserted for 2*EXT_BASE ticks in external mode (`mode`=2'b00). In either internal mode (`mode`=2'b01 short, 2'b10 or 2'b11 long) it stays asserted for 2*INT_UNIT prescaled ticks.
- R3: The first watchdog window after reset ends is the long window, whatever the mode's normal window. It is 4*EXT_BASE ticks in external mode and 16*INT_UNIT ticks in both internal modes.
- R4: After the first strobe edge, the window is EXT_BASE ticks in external mode, INT_UNIT ticks in internal short mode, and 16*INT_UNIT ticks in internal long mode.
- R5: `wdi` passes through a two-flop synchronizer. Both a rising and a falling edge restart the watchdog count, so toggling `wdi` faster than the window keeps reset deasserted indefinitely.
- R6: A watchdog timeout produces a reset pulse of the R2 length. The count then restarts with the long window, so a stalled `wdi` gives pulses repeating at the same spacing.
- R7: `wd_ok_o` goes low at a timeout and stays low until the next `wdi` edge. While `pwr_ok` is low it is high from the next clock onward.
- R8: While `pwr_ok` is low, `wdi` edges are ignored. The first window after the following reset is still the long one.
- R9: `ce_out_n` is a registered copy of `ce_in_n` while `pwr_ok` is high. It is high (inactive) one clock after any cycle with `pwr_ok` low.
- R10: While `wd_en` is low, the watchdog count is frozen and `wd_ok_o` is held high. When `wd_en` returns high, counting resumes from the frozen value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply-valid flag, synchronous |
| wdi | input | 1 | Watchdog strobe from the processor, asynchronous |
| wd_en | input | 1 | Watchdog enable; low freezes the watchdog |
| mode | input | 2 | Time-base select: 00 external, 01 internal short, 1x internal long |
| ext_tick | input | 1 | External tick, one tick per high cycle in external mode |
| ce_in_n | input | 1 | Chip-enable request, active low |
| rst_n_o | output | 1 | Reset to the processor, active low |
| rst_o | output | 1 | Reset to the processor, active high |
| wd_ok_o | output | 1 | Watchdog status, low after a timeout |
| ce_out_n | output | 1 | Gated chip-enable, active low |

## Verification
Reset and `wd_ok_o` change one clock after the edge that sees the causing input. A `wdi` change reaches the counter three clocks after it is driven: two synchronizer flops, then the edge register feeding the counter. The bench drives on the falling edge and samples on the next falling edge. It measures each reset and window length as a run of consecutive samples at one level. In external mode, with `ext_tick` held high, these lengths are exact. For windows started by a strobe edge, the bench waits out the three-clock path first. In internal modes the free-running prescaler phase is unknown, so a span of N ticks is accepted anywhere from (N-1)*PRESCALE+1 to N*PRESCALE clocks.

// File: rtl/wds_pkg.sv
`timescale 1ns/1ps
package wds_pkg;
  // Time-base select encoding on the mode port
  localparam logic [1:0] MODE_EXT   = 2'b00;
  localparam logic [1:0] MODE_SHORT = 2'b01;

  typedef enum logic {
    ST_HOLD = 1'b0,   // reset asserted (supply stretch or timeout pulse)
    ST_RUN  = 1'b1    // reset released, watchdog counting
  } sup_state_t;
endpackage

// File: rtl/wds_wdi_edge.sv
`timescale 1ns/1ps
module wds_wdi_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wdi,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= wdi;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[STAGES-2:0], wdi};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wds_tick.sv
`timescale 1ns/1ps
module wds_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic use_ext,
  input  logic ext_tick,
  output logic tick_o
);
  logic int_tick;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign int_tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst)                               div_q <= '0;
        else if (div_q == PW'(PRESCALE - 1))   div_q <= '0;
        else                                   div_q <= div_q + 1'b1;
      end
      assign int_tick = (div_q == PW'(PRESCALE - 1));
    end
  endgenerate

  assign tick_o = use_ext ? ext_tick : int_tick;
endmodule

// File: rtl/wds_core.sv
`timescale 1ns/1ps
module wds_core
  import wds_pkg::*;
#(
  parameter int EXT_BASE = 1024,
  parameter int INT_UNIT = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       tick,
  input  logic       wdi_edge,
  input  logic       wd_en,
  input  logic [1:0] mode,
  output logic       in_reset,
  output logic       wd_ok
);
  localparam int EXT_MAX = 4 * EXT_BASE;
  localparam int INT_MAX = 16 * INT_UNIT;
  localparam int MAXC    = (EXT_MAX > INT_MAX) ? EXT_MAX : INT_MAX;
  localparam int CW      = $clog2(MAXC + 1);

  sup_state_t    state_q;
  logic [CW-1:0] cnt_q;
  logic          first_q;
  logic          wdo_q;
  logic [CW-1:0] rst_len, norm_win, long_win, win;

  always_comb begin
    if (mode == MODE_EXT) begin
      rst_len  = CW'(2 * EXT_BASE);
      norm_win = CW'(EXT_BASE);
      long_win = CW'(4 * EXT_BASE);
    end else if (mode == MODE_SHORT) begin
      rst_len  = CW'(2 * INT_UNIT);
      norm_win = CW'(INT_UNIT);
      long_win = CW'(16 * INT_UNIT);
    end else begin
      rst_len  = CW'(2 * INT_UNIT);
      norm_win = CW'(16 * INT_UNIT);
      long_win = CW'(16 * INT_UNIT);
    end
    win = first_q ? long_win : norm_win;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      first_q <= 1'b1;
      wdo_q   <= 1'b1;
    end else begin
      case (state_q)
        ST_HOLD: begin
          if (!wd_en || wdi_edge) wdo_q <= 1'b1;
          if (tick) begin
            if (cnt_q == rst_len - 1'b1) begin
              state_q <= ST_RUN;
              cnt_q   <= '0;
              first_q <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (!wd_en) begin
            wdo_q <= 1'b1;
          end else if (wdi_edge) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
            wdo_q   <= 1'b1;
          end else if (tick) begin
            if (cnt_q == win - 1'b1) begin
              state_q <= ST_HOLD;
              cnt_q   <= '0;
              wdo_q   <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign in_reset = (state_q == ST_HOLD);
  assign wd_ok    = wdo_q;
endmodule

// File: rtl/wd_supervisor.sv
`timescale 1ns/1ps
module wd_supervisor
  import wds_pkg::*;
#(
  parameter int EXT_BASE    = 1024,
  parameter int INT_UNIT    = 64,
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_ok,
  input  logic       wdi,
  input  logic       wd_en,
  input  logic [1:0] mode,
  input  logic       ext_tick,
  input  logic       ce_in_n,
  output logic       rst_n_o,
  output logic       rst_o,
  output logic       wd_ok_o,
  output logic       ce_out_n
);
  logic tick, wdi_edge, in_reset;

  wds_wdi_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .wdi(wdi), .edge_o(wdi_edge)
  );

  wds_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .use_ext(mode == MODE_EXT),
    .ext_tick(ext_tick), .tick_o(tick)
  );

  wds_core #(.EXT_BASE(EXT_BASE), .INT_UNIT(INT_UNIT)) u_core (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .tick(tick),
    .wdi_edge(wdi_edge), .wd_en(wd_en), .mode(mode),
    .in_reset(in_reset), .wd_ok(wd_ok_o)
  );

  always_ff @(posedge clk) begin
    if (rst || !pwr_ok) ce_out_n <= 1'b1;
    else                ce_out_n <= ce_in_n;
  end

  assign rst_n_o = !in_reset;
  assign rst_o   = in_reset;
endmodule

// File: rtl/wds_checker.sv
`timescale 1ns/1ps
module wds_checker (
  input logic clk,
  input logic rst,
  input logic pwr_ok,
  input logic ce_in_n,
  input logic rst_n_o,
  input logic rst_o,
  input logic wd_ok_o,
  input logic ce_out_n
);
  // R1
  rst_compl_chk: assert property (@(posedge clk) disable iff (rst)
    rst_o == !rst_n_o);

  // R1
  supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> !rst_n_o);

  // R7
  wdo_forced_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> wd_ok_o);

  // R9
  ce_block_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> ce_out_n);

  // R9
  ce_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |=> ce_out_n == $past(ce_in_n));

  // R6
  wdo_fall_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_ok_o) |-> !rst_n_o);
endmodule

bind wd_supervisor wds_checker i_wds_checker (
  .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .ce_in_n(ce_in_n),
  .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_ok_o(wd_ok_o), .ce_out_n(ce_out_n)
);

// File: tb/test_wd_supervisor.sv
`timescale 1ns/1ps
module test_wd_supervisor;
  localparam int EB = 16;   // EXT_BASE
  localparam int IU = 4;    // INT_UNIT
  localparam int PS = 2;    // PRESCALE
  localparam int RST_E  = 2 * EB;
  localparam int LONG_E = 4 * EB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0, wdi = 1'b0, wd_en = 1'b1, ext_tick = 1'b1, ce_in_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic rst_n_o, rst_o, wd_ok_o, ce_out_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wd_supervisor #(.EXT_BASE(EB), .INT_UNIT(IU), .PRESCALE(PS)) i_wd_supervisor (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .wdi(wdi), .wd_en(wd_en),
    .mode(mode), .ext_tick(ext_tick), .ce_in_n(ce_in_n),
    .rst_n_o(rst_n_o), .rst_o(rst_o), .wd_ok_o(wd_ok_o), .ce_out_n(ce_out_n)
  );

  // {pwr_ok, ce_in_n, expected ce_out_n}
  localparam logic [2:0] VEC [8] = '{
    3'b001, 3'b011, 3'b100, 3'b111, 3'b100, 3'b001, 3'b111, 3'b100
  };

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // consecutive falling-edge samples with rst_n_o at lvl, starting now
  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (rst_n_o == lvl && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic toggle_wdi_wait3();
    wdi = ~wdi;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset rst_n_o", int'(rst_n_o), 0);
    chk("R1 reset rst_o", int'(rst_o), 1);
    chk("R7 reset wd_ok_o", int'(wd_ok_o), 1);
    chk("R9 reset ce_out_n", int'(ce_out_n), 1);

    // R9 / R1 vector walk
    for (int i = 0; i < 8; i++) begin
      pwr_ok  = VEC[i][2];
      ce_in_n = VEC[i][1];
      @(negedge clk);
      chk($sformatf("R9 vec%0d ce_out_n", i), int'(ce_out_n), int'(VEC[i][0]));
      chk($sformatf("R1 vec%0d rst_n_o", i), int'(rst_n_o), 0);
    end

    // external mode, tick every cycle
    pwr_ok = 1'b0; @(negedge clk); @(negedge clk);
    pwr_ok = 1'b1;
    run_len(1'b0, n); chk("R2 ext reset length", n, RST_E);
    run_len(1'b1, n); chk("R3 ext first window", n, LONG_E);
    chk("R7 wd_ok_o low at timeout", int'(wd_ok_o), 0);
    run_len(1'b0, n); chk("R6 timeout pulse length", n, RST_E);
    run_len(1'b1, n); chk("R6 repeat window", n, LONG_E);
    chk("R7 wd_ok_o stays low", int'(wd_ok_o), 0);
    run_len(1'b0, n);
    toggle_wdi_wait3();
    chk("R7 wd_ok_o cleared by edge", int'(wd_ok_o), 1);
    run_len(1'b1, n); chk("R4 ext normal window (rising)", n, EB);
    run_len(1'b0, n);
    toggle_wdi_wait3();
    run_len(1'b1, n); chk("R5 falling edge restarts window", n, EB);
    run_len(1'b0, n);
    bad = 0;
    for (int k = 0; k < 25; k++) begin
      wdi = ~wdi;
      repeat (8) @(negedge clk);
      if (!rst_n_o) bad++;
    end
    chk("R5 toggling keeps reset off", bad, 0);

    // R8: edges during invalid supply ignored
    run_len(1'b1, n);
    chk("R7 wd_ok_o low before drop", int'(wd_ok_o), 0);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R7 wd_ok_o forced high", int'(wd_ok_o), 1);
    chk("R1 rst_n_o on supply drop", int'(rst_n_o), 0);
    for (int k = 0; k < 6; k++) begin
      wdi = ~wdi;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    chk("R8 rst held while invalid", int'(rst_n_o), 0);
    pwr_ok = 1'b1;
    run_len(1'b0, n); chk("R8 reset length after drop", n, RST_E);

    // R10: freeze
    wd_en = 1'b0;
    bad = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!rst_n_o || !wd_ok_o) bad++;
    end
    chk("R10 frozen watchdog no reset", bad, 0);
    wd_en = 1'b1;
    run_len(1'b1, n); chk("R10 resume from frozen count", n, LONG_E);
    run_len(1'b0, n);
    @(negedge clk);
    wd_en = 1'b0;
    @(negedge clk);
    chk("R10 wd_ok_o held high", int'(wd_ok_o), 1);
    wd_en = 1'b1;

    // internal short mode
    pwr_ok = 1'b0; mode = 2'b01; ext_tick = 1'b0;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    run_len(1'b0, n); chk_rng("R2 int reset length", n, (2*IU-1)*PS+1, 2*IU*PS);
    run_len(1'b1, n); chk_rng("R3 short mode first window long", n, (16*IU-1)*PS+1, 16*IU*PS);
    run_len(1'b0, n);
    toggle_wdi_wait3();
    run_len(1'b1, n); chk_rng("R4 short normal window", n, (IU-1)*PS+1, IU*PS);

    // internal long mode
    pwr_ok = 1'b0; mode = 2'b10;
    repeat (2) @(negedge clk);
    pwr_ok = 1'b1;
    run_len(1'b0, n);
    toggle_wdi_wait3();
    run_len(1'b1, n); chk_rng("R4 long normal window", n, (16*IU-1)*PS+1, 16*IU*PS);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule